// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered parallel clock runs at the rate it should, measured against a local reference clock. It counts recovered-clock edges in the recovered domain and carries the running count into the reference domain as Gray code. It then measures how many edges arrived during a fixed window of reference cycles and compares that number with the expected count. The measured error feeds two flags. The first is an active-low lock flag with separate loss and gain thresholds. The second is an error flag that switches at the inner threshold alone.

The recovered clock is always one sixteenth of the line rate. The reference runs at either one sixteenth or one sixty-fourth of the line rate, and a select input says which. The window length in reference cycles is an input and is taken at each window boundary. If the recovered clock stops, a reference-domain idle timer forces both flags to their unlocked state without waiting for the window to end. Both outputs are registers in the reference domain.

Top module: `freq_lock_detector`

## Requirements
- R1: While reset is asserted, and until the end of the second window after reset, `lol_no` is 0 and `sync_err_o` is 1. The first window only records a starting count and produces no verdict.
- R2: The expected count is `win_len_i` when `ref_div16_i` is 1 (reference at line rate / 16). It is 4 × `win_len_i` when `ref_div16_i` is 0 (reference at line rate / 64). A recovered clock at its nominal rate in either mode gives `lol_no` = 1 and `sync_err_o` = 0.
- R3: At the end of an evaluated window, if |N_meas − N_exp| × 10^6 > N_exp × 1000, `lol_no` goes to 0. This applies whether the recovered clock is fast or slow.
- R4: At the end of an evaluated window, if |N_meas − N_exp| × 10^6 ≤ N_exp × 500 and no stall is flagged, `lol_no` goes to 1.
- R5: When the error lies above the 500 ppm bound but not above the 1000 ppm bound, `lol_no` keeps its previous value, whether that value is 0 or 1.
- R6: At the end of each evaluated window with no stall, `sync_err_o` becomes 1 if the error exceeds 500 ppm and 0 otherwise.
- R7: If the synchronized recovered count stays unchanged for `STALL_CYC` consecutive reference cycles, `lol_no` is forced to 0 and `sync_err_o` to 1 on the next cycle. Both stay forced for as long as the stall lasts, even in the middle of a window.
- R8: `win_len_i` and `ref_div16_i` are sampled only at a window boundary. A change in the middle of a window sets the length and ratio of the following window and leaves the current one unchanged.
- R9: Between window ends, and outside a stall, neither output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference clock; all outputs are synchronous to it |
| rec_clk_i | input | 1 | Recovered parallel clock at line rate / 16 |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| ref_div16_i | input | 1 | 1: reference is line rate / 16; 0: line rate / 64 |
| win_len_i | input | WIN_W | Measurement window length in reference cycles (at least 1) |
| lol_no | output | 1 | Loss-of-lock flag, active low (1 means locked) |
| sync_err_o | output | 1 | Frequency error above the inner threshold |

## Verification
The bound checker checks these on every reference cycle: the outputs stay still between window ends (R9); the stall override holds (R7); the reset values are kept until the second window end (R1); and each window verdict follows the threshold comparison, hysteresis hold included (R3 to R6). It cannot show that the Gray transfer and the window arithmetic measure the recovered frequency correctly. For that the bench drives recovered clocks at chosen ppm offsets in both reference ratios, stops the clock in the middle of a window, and changes the window length in the middle of a window.

// File: rtl/fld_pkg.sv
`timescale 1ns/1fs
package fld_pkg;

    // Window controller phases after reset.
    typedef enum logic [1:0] {
        ST_START = 2'd0,   // capture length and ratio
        ST_PRIME = 2'd1,   // first window: baseline snapshot only
        ST_RUN   = 2'd2    // every window end yields a verdict
    } fld_state_e;

    localparam int unsigned PPM_SCALE = 1_000_000;

endpackage

// File: rtl/fld_rec_counter.sv
`timescale 1ns/1fs
module fld_rec_counter #(
    parameter int CW = 24
) (
    input  logic          rec_clk_i,
    input  logic          rst_ni,
    output logic [CW-1:0] gray_o
);

    // Reset is asserted asynchronously and released on the recovered clock.
    logic [1:0] rst_sync_q;
    logic       rec_rst_n;

    always_ff @(posedge rec_clk_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= '0;
        else         rst_sync_q <= {rst_sync_q[0], 1'b1};
    end

    assign rec_rst_n = rst_sync_q[1];

    typedef struct packed {
        logic [CW-1:0] bin;
        logic [CW-1:0] gray;
    } rec_state_t;

    rec_state_t rec_q, rec_d;

    always_comb begin
        rec_d.bin  = rec_q.bin + 1'b1;
        rec_d.gray = rec_d.bin ^ (rec_d.bin >> 1);
    end

    always_ff @(posedge rec_clk_i or negedge rec_rst_n) begin
        if (!rec_rst_n) rec_q <= '0;
        else            rec_q <= rec_d;
    end

    assign gray_o = rec_q.gray;

endmodule

// File: rtl/fld_gray_sync.sv
`timescale 1ns/1fs
module fld_gray_sync #(
    parameter int CW     = 24,
    parameter int STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);

    logic [STAGES-1:0][CW-1:0] sync_d, sync_q;
    logic [CW-1:0]             bin_w;
    logic [CW-1:0]             bin_d, bin_q;

    always_comb begin
        sync_d[0] = gray_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
        bin_d = bin_w;
    end

    // Each binary bit is the XOR of all Gray bits at or above it.
    for (genvar b = 0; b < CW; b++) begin : g_g2b
        assign bin_w[b] = ^sync_q[STAGES-1][CW-1:b];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            bin_q  <= '0;
        end else begin
            sync_q <= sync_d;
            bin_q  <= bin_d;
        end
    end

    assign bin_o = bin_q;

endmodule

// File: rtl/fld_stall_watch.sv
`timescale 1ns/1fs
module fld_stall_watch #(
    parameter int CW        = 24,
    parameter int STALL_CYC = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] cnt_i,
    output logic          stalled_o
);

    localparam int SW = $clog2(STALL_CYC + 1);
    localparam logic [SW-1:0] IDLE_MAX = SW'(STALL_CYC);

    typedef struct packed {
        logic [CW-1:0] prev;
        logic [SW-1:0] idle;
    } watch_t;

    watch_t w_q, w_d;

    always_comb begin
        w_d      = w_q;
        w_d.prev = cnt_i;
        if (cnt_i != w_q.prev) begin
            w_d.idle = '0;
        end else if (w_q.idle != IDLE_MAX) begin
            w_d.idle = w_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) w_q <= '0;
        else         w_q <= w_d;
    end

    assign stalled_o = (w_q.idle == IDLE_MAX);

endmodule

// File: rtl/fld_ppm_judge.sv
`timescale 1ns/1fs
module fld_ppm_judge
    import fld_pkg::*;
#(
    parameter int          CW       = 24,
    parameter int          EW       = 22,
    parameter int unsigned LOSS_PPM = 1000,
    parameter int unsigned GAIN_PPM = 500
) (
    input  logic [CW-1:0] n_meas_i,
    input  logic [EW-1:0] n_exp_i,
    output logic          over_hi_o,
    output logic          over_lo_o
);

    localparam int PW = CW + 21;

    logic [CW-1:0] exp_w;
    logic [CW-1:0] diff_w;
    logic [PW-1:0] scaled_w;
    logic [PW-1:0] hi_lim_w;
    logic [PW-1:0] lo_lim_w;

    // Cross-multiplied compares avoid any divider.
    always_comb begin
        exp_w     = CW'(n_exp_i);
        diff_w    = (n_meas_i >= exp_w) ? (n_meas_i - exp_w) : (exp_w - n_meas_i);
        scaled_w  = PW'(diff_w) * PW'(PPM_SCALE);
        hi_lim_w  = PW'(exp_w) * PW'(LOSS_PPM);
        lo_lim_w  = PW'(exp_w) * PW'(GAIN_PPM);
        over_hi_o = (scaled_w > hi_lim_w);
        over_lo_o = (scaled_w > lo_lim_w);
    end

endmodule

// File: rtl/freq_lock_detector.sv
`timescale 1ns/1fs
module freq_lock_detector
    import fld_pkg::*;
#(
    parameter int          WIN_W       = 20,
    parameter int          CW          = 24,
    parameter int          SYNC_STAGES = 2,
    parameter int          STALL_CYC   = 64,
    parameter int unsigned LOSS_PPM    = 1000,
    parameter int unsigned GAIN_PPM    = 500
) (
    input  logic             ref_clk_i,
    input  logic             rec_clk_i,
    input  logic             rst_ni,
    input  logic             ref_div16_i,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             lol_no,
    output logic             sync_err_o
);

    localparam int EW = WIN_W + 2;

    typedef struct packed {
        fld_state_e       st;
        logic [WIN_W-1:0] wcnt;
        logic [WIN_W-1:0] len;
        logic             div16;
        logic [CW-1:0]    snap;
        logic             lol_n;
        logic             sync_err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:       ST_START,
        wcnt:     '0,
        len:      '0,
        div16:    1'b0,
        snap:     '0,
        lol_n:    1'b0,
        sync_err: 1'b1
    };

    logic [CW-1:0] rec_gray;
    logic [CW-1:0] rec_bin;
    logic          stalled;
    logic [CW-1:0] n_meas;
    logic [EW-1:0] n_exp;
    logic          over_hi;
    logic          over_lo;
    logic          win_end;
    logic          run_eval;
    logic [WIN_W:0] wnext;

    ctl_t ctl_q, ctl_d;

    fld_rec_counter #(.CW(CW)) u_rec_cnt (
        .rec_clk_i (rec_clk_i),
        .rst_ni    (rst_ni),
        .gray_o    (rec_gray)
    );

    fld_gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (ref_clk_i),
        .rst_ni (rst_ni),
        .gray_i (rec_gray),
        .bin_o  (rec_bin)
    );

    fld_stall_watch #(.CW(CW), .STALL_CYC(STALL_CYC)) u_stall (
        .clk_i     (ref_clk_i),
        .rst_ni    (rst_ni),
        .cnt_i     (rec_bin),
        .stalled_o (stalled)
    );

    fld_ppm_judge #(
        .CW(CW), .EW(EW), .LOSS_PPM(LOSS_PPM), .GAIN_PPM(GAIN_PPM)
    ) u_judge (
        .n_meas_i  (n_meas),
        .n_exp_i   (n_exp),
        .over_hi_o (over_hi),
        .over_lo_o (over_lo)
    );

    // Measured and expected counts for the window now ending.
    assign n_meas   = rec_bin - ctl_q.snap;
    assign n_exp    = ctl_q.div16 ? EW'(ctl_q.len) : {ctl_q.len, 2'b00};
    assign wnext    = {1'b0, ctl_q.wcnt} + 1'b1;
    assign win_end  = (ctl_q.st != ST_START) && (wnext >= {1'b0, ctl_q.len});
    assign run_eval = (ctl_q.st == ST_RUN);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_START: begin
                ctl_d.len   = win_len_i;
                ctl_d.div16 = ref_div16_i;
                ctl_d.wcnt  = '0;
                ctl_d.st    = ST_PRIME;
            end
            default: begin
                if (win_end) begin
                    ctl_d.wcnt  = '0;
                    ctl_d.len   = win_len_i;
                    ctl_d.div16 = ref_div16_i;
                    ctl_d.snap  = rec_bin;
                    if (ctl_q.st == ST_PRIME) begin
                        ctl_d.st = ST_RUN;
                    end else begin
                        if (over_hi)      ctl_d.lol_n = 1'b0;
                        else if (!over_lo) ctl_d.lol_n = 1'b1;
                        ctl_d.sync_err = over_lo;
                    end
                end else begin
                    ctl_d.wcnt = ctl_q.wcnt + 1'b1;
                end
            end
        endcase
        if (stalled) begin
            ctl_d.lol_n    = 1'b0;
            ctl_d.sync_err = 1'b1;
        end
    end

    always_ff @(posedge ref_clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= CTL_RST;
        else         ctl_q <= ctl_d;
    end

    assign lol_no     = ctl_q.lol_n;
    assign sync_err_o = ctl_q.sync_err;

endmodule

// File: rtl/fld_lock_checker.sv
`timescale 1ns/1fs
module fld_lock_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic win_end_i,
    input logic run_eval_i,
    input logic stalled_i,
    input logic over_hi_i,
    input logic over_lo_i,
    input logic lol_ni,
    input logic sync_err_i
);

    logic [1:0] ends_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           ends_q <= '0;
        else if (win_end_i && ends_q != 2'd2)  ends_q <= ends_q + 1'b1;
    end

    assert_reset_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ends_q != 2'd2) |-> (!lol_ni && sync_err_i));

    assert_loss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_end_i && run_eval_i && over_hi_i) |=> !lol_ni);

    assert_bound_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        over_hi_i |-> over_lo_i);

    assert_gain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_end_i && run_eval_i && !over_lo_i && !stalled_i) |=> lol_ni);

    assert_hysteresis_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_end_i && run_eval_i && over_lo_i && !over_hi_i && !stalled_i) |=> $stable(lol_ni));

    assert_sync_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_end_i && run_eval_i && !stalled_i) |=> (sync_err_i == $past(over_lo_i)));

    assert_stall_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stalled_i |=> (!lol_ni && sync_err_i));

    assert_quiet_between_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!win_end_i && !stalled_i) |=> ($stable(lol_ni) && $stable(sync_err_i)));

endmodule

bind freq_lock_detector fld_lock_checker u_lock_chk (
    .clk_i      (ref_clk_i),
    .rst_ni     (rst_ni),
    .win_end_i  (win_end),
    .run_eval_i (run_eval),
    .stalled_i  (stalled),
    .over_hi_i  (over_hi),
    .over_lo_i  (over_lo),
    .lol_ni     (lol_no),
    .sync_err_i (sync_err_o)
);

// File: tb/freq_lock_detector_tb.sv
`timescale 1ns/1fs
module freq_lock_detector_tb;

    localparam int WIN_W = 20;
    localparam int L0    = 4000;

    logic             ref_clk = 1'b0;
    logic             rec_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             div16   = 1'b0;
    logic [WIN_W-1:0] win_len = WIN_W'(L0);
    logic             lol_n;
    logic             sync_err;

    int  checks  = 0;
    int  errors  = 0;
    int  cyc     = 0;
    real rec_half = 1.0;
    bit  rec_run = 1'b1;
    bit  done    = 1'b0;

    freq_lock_detector u_dut (
        .ref_clk_i   (ref_clk),
        .rec_clk_i   (rec_clk),
        .rst_ni      (rst_n),
        .ref_div16_i (div16),
        .win_len_i   (win_len),
        .lol_no      (lol_n),
        .sync_err_o  (sync_err)
    );

    initial forever #4 ref_clk = ~ref_clk;

    initial forever begin
        #(rec_half);
        if (rec_run) rec_clk = ~rec_clk;
    end

    always @(posedge ref_clk) if (rst_n) cyc <= cyc + 1;

    // Recovered clock at line/16 with a ppm offset; reference is 125 MHz.
    task automatic set_rec(real ppm, bit mode16);
        rec_half = (mode16 ? 4.0 : 1.0) / (1.0 + ppm * 1.0e-6);
    endtask

    task automatic at_cycle(int c);
        do @(negedge ref_clk); while (cyc < c);
    endtask

    function automatic int wend(int k);
        return 1 + k * L0;
    endfunction

    task automatic check_out(string tag, logic exp_lol, logic exp_sync);
        checks++;
        if (lol_n !== exp_lol || sync_err !== exp_sync) begin
            errors++;
            $display("FAIL %s: lol_n=%0b sync_err=%0b expected lol_n=%0b sync_err=%0b",
                     tag, lol_n, sync_err, exp_lol, exp_sync);
        end
    endtask

    initial begin
        #(150000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, every requirement left unchecked");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f12, f13, f14, f15;
        set_rec(0.0, 1'b0);
        repeat (5) @(negedge ref_clk);
        check_out("R1 in reset", 1'b0, 1'b1);
        rst_n = 1'b1;

        at_cycle(wend(1) - L0 / 2);
        check_out("R1 priming window", 1'b0, 1'b1);
        at_cycle(wend(1) + 20);
        check_out("R1 no verdict after first window", 1'b0, 1'b1);

        at_cycle(wend(2) + 2);   set_rec(750.0, 1'b0);
        at_cycle(wend(2) + 20);  check_out("R2 R4 nominal div64 locks", 1'b1, 1'b0);

        at_cycle(wend(3) + 2);   set_rec(2500.0, 1'b0);
        at_cycle(wend(3) + 20);  check_out("R5 R6 +750ppm holds lock", 1'b1, 1'b1);

        at_cycle(wend(4) + 2);   set_rec(-750.0, 1'b0);
        at_cycle(wend(4) + 20);  check_out("R3 +2500ppm loses lock", 1'b0, 1'b1);

        at_cycle(wend(5) + 2);   set_rec(-250.0, 1'b0);
        at_cycle(wend(5) + 20);  check_out("R5 -750ppm holds unlocked", 1'b0, 1'b1);

        at_cycle(wend(6) + 2);   set_rec(-2500.0, 1'b0);
        at_cycle(wend(6) + 20);  check_out("R4 R6 -250ppm relocks", 1'b1, 1'b0);

        at_cycle(wend(7) + 2);   set_rec(0.0, 1'b0);
        at_cycle(wend(7) + 20);  check_out("R3 -2500ppm loses lock", 1'b0, 1'b1);

        at_cycle(wend(8) + 20);  check_out("R2 nominal relock", 1'b1, 1'b0);

        at_cycle(wend(8) + 100); rec_run = 1'b0;
        at_cycle(wend(8) + 200); check_out("R7 stall forces unlock mid-window", 1'b0, 1'b1);
        at_cycle(wend(8) + 900); check_out("R7 stall held", 1'b0, 1'b1);
        at_cycle(wend(8) + 1000); rec_run = 1'b1;

        at_cycle(wend(9) + 20);  check_out("R3 window with stall gap", 1'b0, 1'b1);
        at_cycle(wend(10) + 20); check_out("R4 lock after stall", 1'b1, 1'b0);

        at_cycle(wend(10) + 1000); win_len = WIN_W'(2000);
        at_cycle(wend(11) + 2);    set_rec(2500.0, 1'b0);
        at_cycle(wend(11) + 20);   check_out("R8 old length kept mid-window", 1'b1, 1'b0);
        at_cycle(wend(11) + 1500); check_out("R9 no change inside window", 1'b1, 1'b0);

        f12 = wend(11) + 2000;
        at_cycle(f12 + 20);   check_out("R8 new length from next window", 1'b0, 1'b1);
        at_cycle(f12 + 1000);
        div16   = 1'b1;
        win_len = WIN_W'(16000);
        set_rec(0.0, 1'b1);

        f13 = f12 + 2000;
        at_cycle(f13 + 20);   check_out("R8 mixed window judged on old ratio", 1'b0, 1'b1);

        f14 = f13 + 16000;
        at_cycle(f14 + 2);    set_rec(2500.0, 1'b1);
        at_cycle(f14 + 20);   check_out("R2 nominal div16 locks", 1'b1, 1'b0);

        f15 = f14 + 16000;
        at_cycle(f15 + 20);   check_out("R3 R6 +2500ppm div16 unlocks", 1'b0, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule